// File: doc/BRIEF.md
# Paired Register Bank for a Serial I/O Expander

This block holds the register state of a 16-bit serial-bus I/O expander. A bit-level front end, not part of this block, turns line activity into one event per clock cycle: start, an address byte that already matched the device, a byte written by the master, a read byte that the master acknowledged or not-acknowledged, and stop. From these events the block keeps eight byte registers. They form four pairs: input levels, output levels, input polarity inversion and pin direction.

In a write transfer the first byte after the address is a command. Its low three bits load the register pointer. Each later byte goes to the register under the pointer, and then the pointer moves to the other member of the same pair by flipping bit 0. It never leaves the pair. A read transfer returns the register under the pointer and alternates in the same way. The pointer is kept across stop and repeated start. The output-level and direction registers drive the pins directly. Reads of the input pair return sampled pin levels XORed with the polarity pair.

Top module: `xpnd_regbank`

## Requirements
- R1: A synchronous high `rst` sets the output pair and the direction pair to all ones, the polarity pair to all zeros, the pointer to 0 and the transfer state to idle (`xfer_busy` low).
- R2: Event codes on `ev_kind` are 0 idle, 1 start, 2 address, 3 write byte, 4 read byte acknowledged, 5 read byte not acknowledged, 6 stop. An address event with bit 0 of `ev_byte` at 0 opens a write phase. In that phase the first write byte is a command, and its bits 2:0 load the pointer.
- R3: Each further write byte in the write phase is stored in the register under the pointer. Bit 0 of the pointer then inverts, so any number of bytes alternate between index pairs 0/1, 2/3, 4/5 and 6/7.
- R4: Write bytes aimed at index 0 or 1 (input pair) change no register, but they still toggle the pointer.
- R5: An address event with bit 0 at 1 opens a read phase. `rd_byte` shows the register under the pointer, and each acknowledged or not-acknowledged read event inverts pointer bit 0.
- R6: Start and stop leave the pointer unchanged, so a new or repeated-start transfer continues at the last pointer. A start always moves the state to awaiting address.
- R7: Events are accepted only inside a transfer opened by start. An address without a start, write bytes before an address, and write bytes in a read phase are all ignored. Stop ends the transfer.
- R8: Indices 0 and 1 read as `pin_in` bytes 0 and 1, XORed with polarity indices 4 and 5. Pin levels pass through one register stage.
- R9: `pin_out` presents indices 3:2 (index 2 in the low byte). `pin_is_in` presents indices 7:6 (index 6 in the low byte), where 1 marks an input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ev_kind | input | 3 | Event code from the bus front end |
| ev_byte | input | BYTE_W | Byte belonging to the event |
| pin_in | input | 2*BYTE_W | Pin levels of both ports |
| rd_byte | output | BYTE_W | Register under the pointer, for the front end to shift out |
| pin_out | output | 2*BYTE_W | Output levels of both ports |
| pin_is_in | output | 2*BYTE_W | Direction per pin, 1 = input |
| xfer_busy | output | 1 | High while a transfer is open |

## Verification
An event takes effect at the clock edge that consumes it. Registers, pointer and `xfer_busy` therefore change at that edge, and `rd_byte`, which is combinational from that state, is valid right after it. A change on `pin_in` reaches `rd_byte` one edge later because of the sampling register. The bench drives each event on a falling edge, holds it for exactly one cycle, and samples on the next falling edge. The pin-latency check samples once before the sampling edge and once after it.

// File: rtl/xpnd_pkg.sv
package xpnd_pkg;

    localparam int IDX_W = 3;

    typedef enum logic [2:0] {
        EV_IDLE  = 3'd0,
        EV_START = 3'd1,
        EV_ADDR  = 3'd2,
        EV_WDATA = 3'd3,
        EV_RACK  = 3'd4,
        EV_RNACK = 3'd5,
        EV_STOP  = 3'd6
    } ev_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_ADDR = 3'd1,
        ST_CMD  = 3'd2,
        ST_WR   = 3'd3,
        ST_RD   = 3'd4
    } xfer_st_e;

    typedef enum logic [1:0] {
        GRP_IN  = 2'd0,
        GRP_OUT = 2'd1,
        GRP_POL = 2'd2,
        GRP_CFG = 2'd3
    } grp_e;

    typedef struct packed {
        grp_e grp;
        logic sel;
    } reg_idx_t;

    function automatic reg_idx_t pair_mate(input reg_idx_t idx);
        reg_idx_t r;
        r     = idx;
        r.sel = ~idx.sel;
        return r;
    endfunction

    function automatic logic idx_writable(input reg_idx_t idx);
        return idx.grp != GRP_IN;
    endfunction

    // fill bit used by a group after reset
    function automatic logic grp_fill(input int g);
        return (g == int'(GRP_OUT)) || (g == int'(GRP_CFG));
    endfunction

endpackage

// File: rtl/xpnd_ctrl.sv
module xpnd_ctrl
    import xpnd_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  ev_kind_e          ev,
    input  logic [BYTE_W-1:0] ev_byte,
    output xfer_st_e          st,
    output reg_idx_t          ptr,
    output logic              wr_en,
    output reg_idx_t          wr_idx,
    output logic [BYTE_W-1:0] wr_data
);

    xfer_st_e st_q;
    reg_idx_t ptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            ptr_q <= '0;
        end else begin
            case (ev)
                EV_START: st_q <= ST_ADDR;
                EV_STOP:  st_q <= ST_IDLE;
                EV_ADDR: begin
                    if (st_q == ST_ADDR)
                        st_q <= ev_byte[0] ? ST_RD : ST_CMD;
                end
                EV_WDATA: begin
                    if (st_q == ST_CMD) begin
                        ptr_q <= reg_idx_t'(ev_byte[IDX_W-1:0]);
                        st_q  <= ST_WR;
                    end else if (st_q == ST_WR) begin
                        ptr_q <= pair_mate(ptr_q);
                    end
                end
                EV_RACK, EV_RNACK: begin
                    if (st_q == ST_RD)
                        ptr_q <= pair_mate(ptr_q);
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        wr_en   = (ev == EV_WDATA) && (st_q == ST_WR) && idx_writable(ptr_q);
        wr_idx  = ptr_q;
        wr_data = ev_byte;
    end

    assign st  = st_q;
    assign ptr = ptr_q;

endmodule

// File: rtl/xpnd_bank.sv
module xpnd_bank
    import xpnd_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  reg_idx_t            wr_idx,
    input  logic [BYTE_W-1:0]   wr_data,
    output logic [2*BYTE_W-1:0] out_word,
    output logic [2*BYTE_W-1:0] pol_word,
    output logic [2*BYTE_W-1:0] cfg_word
);

    localparam int WORD_W = 2 * BYTE_W;
    localparam int NGRP   = 3;

    logic [NGRP*WORD_W-1:0] bank_flat;

    for (genvar g = 1; g <= NGRP; g++) begin : g_grp
        for (genvar p = 0; p < 2; p++) begin : g_port
            logic [BYTE_W-1:0] q;
            always_ff @(posedge clk) begin
                if (rst)
                    q <= {BYTE_W{grp_fill(g)}};
                else if (wr_en && (wr_idx.grp == grp_e'(g)) && (wr_idx.sel == 1'(p)))
                    q <= wr_data;
            end
            assign bank_flat[((g-1)*2+p)*BYTE_W +: BYTE_W] = q;
        end
    end

    assign out_word = bank_flat[0*WORD_W +: WORD_W];
    assign pol_word = bank_flat[1*WORD_W +: WORD_W];
    assign cfg_word = bank_flat[2*WORD_W +: WORD_W];

endmodule

// File: rtl/xpnd_rdmux.sv
module xpnd_rdmux
    import xpnd_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic [2*BYTE_W-1:0] pin_in,
    input  reg_idx_t            ptr,
    input  logic [2*BYTE_W-1:0] out_word,
    input  logic [2*BYTE_W-1:0] pol_word,
    input  logic [2*BYTE_W-1:0] cfg_word,
    output logic [BYTE_W-1:0]   rd_byte
);

    logic [2*BYTE_W-1:0] pin_q;
    logic [2*BYTE_W-1:0] word;

    always_ff @(posedge clk) begin
        pin_q <= pin_in;
    end

    always_comb begin
        case (ptr.grp)
            GRP_IN:  word = pin_q ^ pol_word;
            GRP_OUT: word = out_word;
            GRP_POL: word = pol_word;
            default: word = cfg_word;
        endcase
        rd_byte = ptr.sel ? word[BYTE_W +: BYTE_W] : word[0 +: BYTE_W];
    end

endmodule

// File: rtl/xpnd_regbank.sv
module xpnd_regbank
    import xpnd_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [2:0]          ev_kind,
    input  logic [BYTE_W-1:0]   ev_byte,
    input  logic [2*BYTE_W-1:0] pin_in,
    output logic [BYTE_W-1:0]   rd_byte,
    output logic [2*BYTE_W-1:0] pin_out,
    output logic [2*BYTE_W-1:0] pin_is_in,
    output logic                xfer_busy
);

    xfer_st_e            st;
    reg_idx_t            ptr;
    logic                wr_en;
    reg_idx_t            wr_idx;
    logic [BYTE_W-1:0]   wr_data;
    logic [2*BYTE_W-1:0] out_word;
    logic [2*BYTE_W-1:0] pol_word;
    logic [2*BYTE_W-1:0] cfg_word;
    logic [2:0]          st_w;
    logic [2:0]          ptr_w;

    xpnd_ctrl #(.BYTE_W(BYTE_W)) ctrl_i (
        .clk     (clk),
        .rst     (rst),
        .ev      (ev_kind_e'(ev_kind)),
        .ev_byte (ev_byte),
        .st      (st),
        .ptr     (ptr),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data)
    );

    xpnd_bank #(.BYTE_W(BYTE_W)) bank_i (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .out_word (out_word),
        .pol_word (pol_word),
        .cfg_word (cfg_word)
    );

    xpnd_rdmux #(.BYTE_W(BYTE_W)) rdmux_i (
        .clk      (clk),
        .pin_in   (pin_in),
        .ptr      (ptr),
        .out_word (out_word),
        .pol_word (pol_word),
        .cfg_word (cfg_word),
        .rd_byte  (rd_byte)
    );

    assign pin_out   = out_word;
    assign pin_is_in = cfg_word;
    assign xfer_busy = (st != ST_IDLE);
    assign st_w      = st;
    assign ptr_w     = ptr;

endmodule

// File: rtl/xpnd_regbank_chk.sv
module xpnd_regbank_chk
    import xpnd_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input logic                clk,
    input logic                rst,
    input logic [2:0]          ev_kind,
    input logic [2:0]          cmd_bits,
    input logic [2:0]          st,
    input logic [2:0]          ptr,
    input logic [2*BYTE_W-1:0] pin_out,
    input logic [2*BYTE_W-1:0] pin_is_in,
    input logic                xfer_busy
);

    logic rst_seen_q;

    always_ff @(posedge clk) begin
        rst_seen_q <= rst;
        if (rst_seen_q === 1'b1) begin
            AST_RESET_DEFAULTS: assert (pin_out == '1 && pin_is_in == '1 && !xfer_busy && ptr == 3'd0); // R1
        end
    end

    AST_CMD_LOADS_PTR: assert property (@(posedge clk) disable iff (rst)
        (st == ST_CMD && ev_kind == EV_WDATA) |=> (ptr == $past(cmd_bits))); // R2

    AST_WR_PAIR_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        (st == ST_WR && ev_kind == EV_WDATA) |=> (ptr == ($past(ptr) ^ 3'b001))); // R3

    AST_INPUT_PAIR_READONLY: assert property (@(posedge clk) disable iff (rst)
        (st == ST_WR && ev_kind == EV_WDATA && ptr[2:1] == 2'b00)
        |=> ($stable(pin_out) && $stable(pin_is_in))); // R4

    AST_RD_PAIR_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RD && (ev_kind == EV_RACK || ev_kind == EV_RNACK))
        |=> (ptr == ($past(ptr) ^ 3'b001))); // R5

    AST_START_KEEPS_PTR: assert property (@(posedge clk) disable iff (rst)
        (ev_kind == EV_START) |=> ($stable(ptr) && st == ST_ADDR)); // R6

    AST_STOP_ENDS_XFER: assert property (@(posedge clk) disable iff (rst)
        (ev_kind == EV_STOP) |=> !xfer_busy); // R7

    AST_NO_ADDR_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && ev_kind == EV_ADDR) |=> !xfer_busy); // R7

endmodule

bind xpnd_regbank xpnd_regbank_chk #(.BYTE_W(BYTE_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .ev_kind   (ev_kind),
    .cmd_bits  (ev_byte[2:0]),
    .st        (st_w),
    .ptr       (ptr_w),
    .pin_out   (pin_out),
    .pin_is_in (pin_is_in),
    .xfer_busy (xfer_busy)
);

// File: tb/xpnd_regbank_tb.sv
module xpnd_regbank_tb_top;

    localparam int BW = 8;

    localparam logic [2:0] K_IDLE  = 3'd0;
    localparam logic [2:0] K_START = 3'd1;
    localparam logic [2:0] K_ADDR  = 3'd2;
    localparam logic [2:0] K_WD    = 3'd3;
    localparam logic [2:0] K_RACK  = 3'd4;
    localparam logic [2:0] K_RNACK = 3'd5;
    localparam logic [2:0] K_STOP  = 3'd6;

    typedef struct packed {
        logic [2:0] k;
        logic [7:0] b;
        logic [3:0] req;
        logic [7:0] exp;
    } vec_t;

    localparam int NVEC = 29;

    // pins held at 16'h3CA5: port0 = A5, port1 = 3C
    localparam vec_t VEC [NVEC] = '{
        '{K_IDLE,  8'h00, 4'd8, 8'hA5},  // R8 input pair, no inversion
        '{K_START, 8'h00, 4'd6, 8'hA5},  // R6
        '{K_ADDR,  8'h40, 4'd2, 8'hA5},  // R2 write address
        '{K_WD,    8'h03, 4'd2, 8'hFF},  // R2 command -> ptr 3
        '{K_WD,    8'h11, 4'd3, 8'hFF},  // R3 reg3=11, ptr 2
        '{K_WD,    8'h22, 4'd3, 8'h11},  // R3 reg2=22, ptr 3
        '{K_WD,    8'h33, 4'd3, 8'h22},  // R3 reg3=33, ptr 2
        '{K_STOP,  8'h00, 4'd6, 8'h22},  // R6
        '{K_START, 8'h00, 4'd6, 8'h22},  // R6
        '{K_ADDR,  8'h41, 4'd5, 8'h22},  // R5 read address
        '{K_RACK,  8'h00, 4'd5, 8'h33},  // R5
        '{K_RNACK, 8'h00, 4'd5, 8'h22},  // R5
        '{K_START, 8'h00, 4'd6, 8'h22},  // R6 repeated start
        '{K_ADDR,  8'h40, 4'd2, 8'h22},  // R2
        '{K_WD,    8'h04, 4'd2, 8'h00},  // R2 ptr 4
        '{K_WD,    8'hFF, 4'd3, 8'h00},  // R3 pol0=FF, ptr 5
        '{K_WD,    8'h0F, 4'd3, 8'hFF},  // R3 pol1=0F, ptr 4
        '{K_START, 8'h00, 4'd6, 8'hFF},  // R6
        '{K_ADDR,  8'h40, 4'd2, 8'hFF},  // R2
        '{K_WD,    8'h00, 4'd8, 8'h5A},  // R8 A5^FF
        '{K_WD,    8'h77, 4'd4, 8'h33},  // R4 ignored, 3C^0F
        '{K_WD,    8'h88, 4'd4, 8'h5A},  // R4 ignored
        '{K_STOP,  8'h00, 4'd7, 8'h5A},  // R7
        '{K_WD,    8'h06, 4'd7, 8'h5A},  // R7 data with no transfer
        '{K_ADDR,  8'h40, 4'd7, 8'h5A},  // R7 address without start
        '{K_WD,    8'h06, 4'd7, 8'h5A},  // R7
        '{K_START, 8'h00, 4'd7, 8'h5A},  // R7
        '{K_WD,    8'h06, 4'd7, 8'h5A},  // R7 data before address
        '{K_STOP,  8'h00, 4'd7, 8'h5A}   // R7
    };

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [2:0]      ev_kind = K_IDLE;
    logic [BW-1:0]   ev_byte = '0;
    logic [2*BW-1:0] pin_in = 16'h3CA5;
    logic [BW-1:0]   rd_byte;
    logic [2*BW-1:0] pin_out;
    logic [2*BW-1:0] pin_is_in;
    logic            xfer_busy;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #10 clk = ~clk;

    xpnd_regbank #(.BYTE_W(BW)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .ev_kind   (ev_kind),
        .ev_byte   (ev_byte),
        .pin_in    (pin_in),
        .rd_byte   (rd_byte),
        .pin_out   (pin_out),
        .pin_is_in (pin_is_in),
        .xfer_busy (xfer_busy)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [2:0] k, input logic [7:0] b);
        ev_kind = k;
        ev_byte = b;
        @(negedge clk);
        ev_kind = K_IDLE;
        ev_byte = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 pin_out after reset", pin_out, 16'hFFFF);
        chk("R1 pin_is_in after reset", pin_is_in, 16'hFFFF);
        chk("R1 busy after reset", {15'd0, xfer_busy}, 16'd0);
        chk("R1 read ptr 0 after reset", {8'd0, rd_byte}, 16'h00A5);

        for (int i = 0; i < NVEC; i++) begin
            send(VEC[i].k, VEC[i].b);
            n_chk++;
            if (rd_byte !== VEC[i].exp) begin
                n_fail++;
                $display("FAIL R%0d vector %0d rd_byte actual %h expected %h",
                         VEC[i].req, i, rd_byte, VEC[i].exp);
            end
        end

        // R9 pin views
        chk("R9 pin_out", pin_out, 16'h3322);
        chk("R9 pin_is_in default", pin_is_in, 16'hFFFF);
        send(K_START, 8'h00);
        send(K_ADDR, 8'h40);
        send(K_WD, 8'h06);
        send(K_WD, 8'hF0);
        send(K_WD, 8'h0F);
        send(K_STOP, 8'h00);
        chk("R9 pin_is_in written", pin_is_in, 16'h0FF0);

        // R7 write byte inside read phase
        send(K_START, 8'h00);
        send(K_ADDR, 8'h41);
        chk("R7 busy in read", {15'd0, xfer_busy}, 16'd1);
        send(K_WD, 8'h99);
        chk("R7 read-phase data ignored rd", {8'd0, rd_byte}, 16'h00F0);
        chk("R7 read-phase data ignored cfg", pin_is_in, 16'h0FF0);
        send(K_STOP, 8'h00);
        chk("R7 stop clears busy", {15'd0, xfer_busy}, 16'd0);

        // R8 one-stage pin latency
        send(K_START, 8'h00);
        send(K_ADDR, 8'h40);
        send(K_WD, 8'h00);
        send(K_STOP, 8'h00);
        pin_in = 16'h3C00;
        #1;
        chk("R8 pin before sampling edge", {8'd0, rd_byte}, 16'h005A);
        @(negedge clk);
        chk("R8 pin after sampling edge", {8'd0, rd_byte}, 16'h00FF);

        // R1 reset in mid-run
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 pin_out reset", pin_out, 16'hFFFF);
        chk("R1 pin_is_in reset", pin_is_in, 16'hFFFF);
        chk("R1 pol cleared, ptr 0", {8'd0, rd_byte}, 16'h0000);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule